// File: doc/BRIEF.md
# Broadcast Message Distributor

This block keeps one small shared memory region consistent across a group of sixteen processors without coherent caches. Each processor owns a local copy of the region. When a processor stores into its copy, the store is also queued at that source as a message holding a word address, 32 bits of data and a 4-bit byte enable. A round-robin arbiter picks one queued message per cycle and places it on a common broadcast bus. Every other processor applies the message to its own copy in the same cycle.

Each receiver has an inclusive address window. An arriving message whose address lies inside the window pushes that address into the receiver's ordered arrival FIFO. The receiver's interrupt stays high while that FIFO holds entries. Software therefore pops addresses one at a time and does not need to scan the whole region. A source whose queue is full stalls its writer.

Top module: `msg_broadcast`

## Requirements
- R1: After reset every local copy reads zero, every wrReady is high, and every irq and rxOverflow is low.
- R2: A write accepted at clock edge E updates the writer's own copy at E. With the bus idle, every other copy shows it at edge E+2, and all of them in that same cycle.
- R3: The bus carries at most one message per cycle. Pending sources are served in cyclic index order, starting after the source last served, so each source sends at most once per round of sixteen.
- R4: Each source holds up to 18 pending messages. While all 18 are occupied wrReady is low and the write waits. Once space frees, no accepted message is lost.
- R5: Byte-enable bit k selects data bits 8k+7..8k. Bytes whose enable bit is clear keep their old value in every copy.
- R6: A source never receives its own message. Its own window therefore never fires on its own writes.
- R7: A message at address a is logged by a receiver only when winLo <= a <= winHi. Messages outside the window still update the copy.
- R8: irq is high exactly while the arrival FIFO is non-empty. rxAddr shows the oldest entry, a pulse on rxPop removes it, and addresses come out in arrival order.
- R9: An in-window arrival that finds the 16-entry arrival FIFO full is discarded. It sets rxOverflow, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 16 | Per-processor write request into the region |
| wrAddr | input | 16x6 | Per-processor word address |
| wrData | input | 16x32 | Per-processor write data |
| wrBe | input | 16x4 | Per-processor byte enables |
| wrReady | output | 16 | Source queue has room; write accepted when valid and ready |
| rdAddr | input | 16x6 | Per-processor read address into its local copy |
| rdData | output | 16x32 | Combinational read data from the local copy |
| winLo | input | 16x6 | Lower bound of the receive window (inclusive) |
| winHi | input | 16x6 | Upper bound of the receive window (inclusive) |
| irq | output | 16 | Arrival FIFO non-empty |
| rxPop | input | 16 | Remove the oldest arrival address |
| rxAddr | output | 16x6 | Oldest arrival address |
| rxOverflow | output | 16 | Sticky flag for a dropped arrival |

## Verification
A lone write with the bus idle pins down the two-cycle remote latency and shows that all receivers update together. The same write separates the sender's missing self-delivery from a receiver's window hit. Writes that straddle a window's edges tell an inclusive bound from an exclusive one and confirm that out-of-window data still lands. One burst from fifteen sources in the same cycle exposes the cyclic service order through the arrival sequence. A sustained flood from all sixteen fills the source queues and a receiver FIFO, which tests stalling, loss-free draining and the sticky overflow flag. A partial byte-enable write shows merging at byte granularity.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  localparam int NP        = 16;
  localparam int AW        = 6;
  localparam int DW        = 32;
  localparam int BW        = DW / 8;
  localparam int SRC_SLOTS = 18;
  localparam int RX_DEPTH  = 16;
  localparam int WORDS     = 1 << AW;
  localparam int SW        = $clog2(NP);
  localparam int CW        = $clog2(SRC_SLOTS + 1);
  localparam int PW        = $clog2(SRC_SLOTS);
  localparam int RXW       = $clog2(RX_DEPTH);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [BW-1:0] be;
  } msg_t;

  typedef struct packed {
    logic [NP-1:0] push;
    logic [NP-1:0] pop;
    logic          busLoad;
    logic [SW-1:0] grant;
  } ctrl_t;
endpackage

// File: rtl/bcast_ctrl.sv
module bcast_ctrl
  import bcast_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [NP-1:0] wrValid,
  output logic [NP-1:0] wrReady,
  output ctrl_t         st
);
  localparam logic [CW-1:0] SLOTS_FULL = CW'(SRC_SLOTS);

  logic [CW-1:0] cnt [NP];
  logic [SW-1:0] ptr;
  logic [SW-1:0] idx;
  logic          found;
  logic [SW-1:0] grantIdx;

  for (genvar i = 0; i < NP; i++) begin : g_ready
    assign wrReady[i] = (cnt[i] != SLOTS_FULL);
  end

  always_comb begin
    found    = 1'b0;
    grantIdx = '0;
    idx      = '0;
    for (int k = 0; k < NP; k++) begin
      idx = ptr + SW'(k);
      if (!found && cnt[idx] != '0) begin
        found    = 1'b1;
        grantIdx = idx;
      end
    end
    st.push    = wrValid & wrReady;
    st.busLoad = found;
    st.grant   = grantIdx;
    st.pop     = found ? (NP'(1) << grantIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (found) begin
      ptr <= grantIdx + SW'(1);
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) cnt[i] <= '0;
      else       cnt[i] <= cnt[i] + CW'(st.push[i]) - CW'(st.pop[i]);
    end

    // R4
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      cnt[i] <= SLOTS_FULL);

    // R4
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[i] == SLOTS_FULL && !st.pop[i]) |=> cnt[i] == SLOTS_FULL);
  end

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.pop));
endmodule

// File: rtl/bcast_dp.sv
module bcast_dp
  import bcast_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_t                  st,
  input  logic [NP-1:0][AW-1:0]  wrAddr,
  input  logic [NP-1:0][DW-1:0]  wrData,
  input  logic [NP-1:0][BW-1:0]  wrBe,
  input  logic [NP-1:0][AW-1:0]  rdAddr,
  output logic [NP-1:0][DW-1:0]  rdData,
  input  logic [NP-1:0][AW-1:0]  winLo,
  input  logic [NP-1:0][AW-1:0]  winHi,
  output logic [NP-1:0]          irq,
  input  logic [NP-1:0]          rxPop,
  output logic [NP-1:0][AW-1:0]  rxAddr,
  output logic [NP-1:0]          rxOverflow
);
  localparam logic [PW-1:0]  LAST_SLOT = PW'(SRC_SLOTS - 1);
  localparam logic [RXW:0]   RX_FULL   = (RXW + 1)'(RX_DEPTH);

  msg_t [NP-1:0] heads;
  logic          busValid;
  msg_t          busMsg;
  logic [SW-1:0] busSrc;

  // Source queues
  for (genvar s = 0; s < NP; s++) begin : g_src
    msg_t          srcMem [SRC_SLOTS];
    logic [PW-1:0] wp, rp;

    assign heads[s] = srcMem[rp];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (st.push[s]) begin
          srcMem[wp] <= '{addr: wrAddr[s], data: wrData[s], be: wrBe[s]};
          wp <= (wp == LAST_SLOT) ? '0 : wp + PW'(1);
        end
        if (st.pop[s]) rp <= (rp == LAST_SLOT) ? '0 : rp + PW'(1);
      end
    end
  end

  // Broadcast bus register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busMsg   <= '0;
      busSrc   <= '0;
    end else begin
      busValid <= st.busLoad;
      if (st.busLoad) begin
        busMsg <= heads[st.grant];
        busSrc <= st.grant;
      end
    end
  end

  // Receivers
  for (genvar r = 0; r < NP; r++) begin : g_rx
    logic [DW-1:0]  mem   [WORDS];
    logic [AW-1:0]  rxMem [RX_DEPTH];
    logic [RXW-1:0] rxWp, rxRp;
    logic [RXW:0]   rxCnt;
    logic           remote, hit, doPop, doPush, ovf;

    assign remote = busValid && (busSrc != SW'(r));
    assign hit    = remote && (busMsg.addr >= winLo[r]) && (busMsg.addr <= winHi[r]);
    assign doPop  = rxPop[r] && (rxCnt != '0);
    assign doPush = hit && ((rxCnt != RX_FULL) || doPop);

    assign rdData[r]     = mem[rdAddr[r]];
    assign rxAddr[r]     = rxMem[rxRp];
    assign irq[r]        = (rxCnt != '0);
    assign rxOverflow[r] = ovf;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else begin
        if (remote) begin
          for (int b = 0; b < BW; b++)
            if (busMsg.be[b]) mem[busMsg.addr][b*8 +: 8] <= busMsg.data[b*8 +: 8];
        end
        if (st.push[r]) begin
          for (int b = 0; b < BW; b++)
            if (wrBe[r][b]) mem[wrAddr[r]][b*8 +: 8] <= wrData[r][b*8 +: 8];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxWp  <= '0;
        rxRp  <= '0;
        rxCnt <= '0;
        ovf   <= 1'b0;
      end else begin
        if (doPush) begin
          rxMem[rxWp] <= busMsg.addr;
          rxWp <= rxWp + RXW'(1);
        end
        if (doPop) rxRp <= rxRp + RXW'(1);
        rxCnt <= rxCnt + (RXW + 1)'(doPush) - (RXW + 1)'(doPop);
        if (hit && !doPush) ovf <= 1'b1;
      end
    end

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[r]) |-> ($past(busValid) && $past(busSrc) != SW'(r)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      rxOverflow[r] |=> rxOverflow[r]);

    // R8
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      rxCnt <= RX_FULL);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irq[r] && !rxPop[r]) |=> irq[r]);
  end
endmodule

// File: rtl/msg_broadcast.sv
module msg_broadcast
  import bcast_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NP-1:0]          wrValid,
  input  logic [NP-1:0][AW-1:0]  wrAddr,
  input  logic [NP-1:0][DW-1:0]  wrData,
  input  logic [NP-1:0][BW-1:0]  wrBe,
  output logic [NP-1:0]          wrReady,
  input  logic [NP-1:0][AW-1:0]  rdAddr,
  output logic [NP-1:0][DW-1:0]  rdData,
  input  logic [NP-1:0][AW-1:0]  winLo,
  input  logic [NP-1:0][AW-1:0]  winHi,
  output logic [NP-1:0]          irq,
  input  logic [NP-1:0]          rxPop,
  output logic [NP-1:0][AW-1:0]  rxAddr,
  output logic [NP-1:0]          rxOverflow
);
  ctrl_t st;

  bcast_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .st(st)
  );

  bcast_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .rdAddr(rdAddr), .rdData(rdData),
    .winLo(winLo), .winHi(winHi),
    .irq(irq), .rxPop(rxPop), .rxAddr(rxAddr), .rxOverflow(rxOverflow)
  );
endmodule

// File: tb/tb_msg_broadcast.sv
module tb_msg_broadcast;
  import bcast_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [NP-1:0]         wrValid = '0;
  logic [NP-1:0][AW-1:0] wrAddr = '0;
  logic [NP-1:0][DW-1:0] wrData = '0;
  logic [NP-1:0][BW-1:0] wrBe = '0;
  logic [NP-1:0]         wrReady;
  logic [NP-1:0][AW-1:0] rdAddr = '0;
  logic [NP-1:0][DW-1:0] rdData;
  logic [NP-1:0][AW-1:0] winLo = '1;
  logic [NP-1:0][AW-1:0] winHi = '0;
  logic [NP-1:0]         irq;
  logic [NP-1:0]         rxPop = '0;
  logic [NP-1:0][AW-1:0] rxAddr;
  logic [NP-1:0]         rxOverflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msg_broadcast dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(int s, int a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wrValid[s] = 1'b1; wrAddr[s] = AW'(a); wrData[s] = d; wrBe[s] = be;
    @(negedge clk);
    wrValid[s] = 1'b0;
  endtask

  task automatic pop1(int r);
    @(negedge clk);
    rxPop[r] = 1'b1;
    @(negedge clk);
    rxPop[r] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wrReady", 32'(wrReady), 32'(16'hFFFF));
    chk("R1 irq", 32'(irq), 0);
    chk("R1 overflow", 32'(rxOverflow), 0);
    rdAddr[3] = 6'd0;
    #1 chk("R1 copy zero", rdData[3], 0);
  endtask

  task automatic t_latency();
    int bad = 0;
    winLo[2] = 6'd5; winHi[2] = 6'd5;
    winLo[9] = 6'd4; winHi[9] = 6'd6;
    for (int r = 0; r < NP; r++) rdAddr[r] = 6'd5;
    @(negedge clk);
    wrValid[2] = 1'b1; wrAddr[2] = 6'd5; wrData[2] = 32'hA5A5_0001; wrBe[2] = 4'hF;
    @(negedge clk);  // after E0
    wrValid[2] = 1'b0;
    chk("R2 own copy at E", rdData[2], 32'hA5A5_0001);
    chk("R2 remote old at E", rdData[7], 0);
    @(negedge clk);  // after E1
    chk("R2 remote old at E+1", rdData[7], 0);
    @(negedge clk);  // after E2
    for (int r = 0; r < NP; r++)
      if (r != 2 && rdData[r] !== 32'hA5A5_0001) bad++;
    chk("R2 all remotes at E+2", 32'(bad), 0);
    chk("R7 window hit irq", 32'(irq[9]), 1);
    chk("R8 rxAddr", 32'(rxAddr[9]), 5);
    tick(2);
    chk("R6 no self delivery", 32'(irq[2]), 0);
    chk("R6 own copy kept", rdData[2], 32'hA5A5_0001);
    pop1(9);
    chk("R8 irq clears after pop", 32'(irq[9]), 0);
  endtask

  task automatic t_bytes();
    wr1(4, 10, 32'h1111_1111, 4'hF);
    wr1(4, 10, 32'hAABB_CCDD, 4'b0101);
    tick(4);
    rdAddr[6] = 6'd10;
    #1 chk("R5 byte merge", rdData[6], 32'h11BB_11DD);
  endtask

  task automatic t_window();
    winLo[9] = 6'd20; winHi[9] = 6'd22;
    wr1(1, 19, 32'h19, 4'hF);
    wr1(1, 20, 32'h20, 4'hF);
    wr1(1, 22, 32'h22, 4'hF);
    wr1(1, 23, 32'h23, 4'hF);
    tick(4);
    chk("R8 irq set", 32'(irq[9]), 1);
    chk("R7 low bound inclusive", 32'(rxAddr[9]), 20);
    pop1(9);
    chk("R7 high bound inclusive", 32'(rxAddr[9]), 22);
    pop1(9);
    chk("R7 outside not logged", 32'(irq[9]), 0);
    rdAddr[9] = 6'd19;
    #1 chk("R7 outside still updates", rdData[9], 32'h19);
  endtask

  task automatic t_rr();
    int prev;
    winLo[15] = 6'd0; winHi[15] = 6'd63;
    winLo[9] = '1; winHi[9] = '0;
    @(negedge clk);
    for (int s = 0; s < 15; s++) begin
      wrValid[s] = 1'b1; wrAddr[s] = AW'(s); wrData[s] = 32'(s); wrBe[s] = 4'hF;
    end
    @(negedge clk);
    wrValid = '0;
    tick(20);
    prev = int'(rxAddr[15]);
    for (int k = 1; k < 15; k++) begin
      pop1(15);
      chk("R3 cyclic order", 32'(rxAddr[15]), 32'((prev + 1) % 15));
      prev = int'(rxAddr[15]);
    end
    pop1(15);
    chk("R3 fifteen arrivals", 32'(irq[15]), 0);
    chk("R9 no overflow yet", 32'(rxOverflow[15]), 0);
  endtask

  task automatic t_stall();
    logic [31:0] val [NP];
    logic [31:0] last [NP];
    int acc0 = 0;
    bit sawFull = 0;
    winLo[15] = 6'd32; winHi[15] = 6'd47;
    for (int s = 0; s < NP; s++) begin
      val[s] = {8'(s), 24'd1};
      last[s] = 0;
    end
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      for (int s = 0; s < NP; s++) begin
        wrValid[s] = 1'b1; wrAddr[s] = AW'(32 + s); wrData[s] = val[s]; wrBe[s] = 4'hF;
        if (wrReady[s]) begin
          last[s] = val[s];
          val[s] = val[s] + 1;
          if (s == 0) acc0++;
        end else if (s == 0) sawFull = 1;
      end
    end
    @(negedge clk);
    wrValid = '0;
    tick(400);
    chk("R4 writer stalled", 32'(sawFull), 1);
    chk("R4 accepted at least 18", 32'(acc0 >= 18), 1);
    chk("R4 accepted fewer than offered", 32'(acc0 < 40), 1);
    rdAddr[1] = 6'd32; rdAddr[0] = 6'd33;
    #1;
    chk("R4 last src0 delivered", rdData[1], last[0]);
    chk("R4 last src1 delivered", rdData[0], last[1]);
    chk("R9 overflow set", 32'(rxOverflow[15]), 1);
    chk("R8 irq while full", 32'(irq[15]), 1);
    pop1(15);
    chk("R9 overflow sticky", 32'(rxOverflow[15]), 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_latency();
    t_bytes();
    t_window();
    t_rr();
    t_stall();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule